// File: doc/BRIEF.md
# Two-Probe Hashed Direct-Mapped Cache Lookup

This block is the lookup stage of a small direct-mapped data cache that several hardware threads share. Each accepted request carries an address and a thread number. The array is looked up first at the slot named by the plain index bits of the address. Only when that probe misses does a second probe follow. The second probe uses a hashed slot, which is the index XORed with the low tag bits. The two probes together give the array most of the benefit of two ways without a second tag bank. Lines that belong to different threads keep apart because the thread number is stored and compared with the tag.

When both probes miss, the block asks an external memory for the whole line with a level request. The memory answers with a one-cycle acknowledge that carries the line data. The new line is written into the hashed slot if that slot is empty, and into the plain slot otherwise. Every stored line remembers which of the two index functions placed it, so a probe through the other function cannot take it for a hit. Only one request is in flight at a time. The response is a single-cycle pulse and has no backpressure.

Top module: `dual_probe_cache`

## Requirements
- R1: After reset every line is invalid, `reqReady` is 1, and both `respValid` and `memReqValid` are 0. The first lookup to any address therefore misses on both probes.
- R2: The address is split, from MSB to LSB, into tag (TAG_W bits), index (IDX_W bits) and word offset (OFF_W bits). `respData` is the word at that offset in the line, and word k occupies bits [k*DATA_W +: DATA_W] of the line.
- R3: A hit on the primary probe gives a response one cycle after the request is accepted. That response has `respHit`=1, `respSecond`=0 and `respSlot` equal to the index.
- R4: The hashed slot is the index XOR tag[IDX_W-1:0]. A hit on the secondary probe gives a response two cycles after acceptance, with `respHit`=1, `respSecond`=1 and `respSlot` equal to the hashed slot. If the primary probe hits, no secondary response is given.
- R5: A lookup hits only a line whose stored thread number equals `reqThread`. The same address from another thread misses.
- R6: A line placed through one index function never gives a hit to a probe through the other index function, even when the stored tag and thread match.
- R7: On a miss of both probes, `memReqValid` rises three cycles after acceptance and stays high until `memAck`. Throughout that time `memReqAddr` = {tag, index} is stable.
- R8: The line given with `memAck` is written into the hashed slot if that slot is invalid, and otherwise into the primary slot. One cycle after `memAck` a response follows with `respHit`=0, `respSlot` set to the written slot, and `respData` set to the addressed word of the new line.
- R9: `reqReady` is 0 from the cycle after acceptance up to and including the response cycle, and it is 1 again in the cycle after the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lookup request present |
| reqReady | output | 1 | Block is idle and accepts a request |
| reqAddr | input | TAG_W+IDX_W+OFF_W | Byte-free word address: tag, index, offset |
| reqThread | input | THR_W | Requesting thread number |
| respValid | output | 1 | One-cycle response pulse |
| respHit | output | 1 | 1 for a hit, 0 for a response after a fill |
| respSecond | output | 1 | Hit came from the hashed probe |
| respSlot | output | IDX_W | Array slot that holds the line |
| respData | output | DATA_W | Addressed word of the line |
| memReqValid | output | 1 | Line fetch request, held until acknowledged |
| memReqAddr | output | TAG_W+IDX_W | Line address {tag, index} |
| memAck | input | 1 | One-cycle fetch acknowledge with data |
| memData | input | DATA_W<<OFF_W | Fetched line |

## Verification
The bench first runs directed sequences. These check the first miss after reset, a line that lands in the hashed slot and later hits on the second probe, the same address from the other thread, and a line whose tag matches but was placed by the other index function. It also checks a tag whose low bits are zero, so both index functions pick the same slot. It then sweeps every line address for both threads twice, with a fill delay that varies, and compares against a slot-by-slot model. Hit latency, slot, probe and word show whether the probe order, the hash, the victim choice and the word select are right.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRI,
    ST_ALT,
    ST_FILL,
    ST_RESP
  } ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic captureReq;  // latch request fields
    logic selAlt;      // compare at hashed slot
    logic selFill;     // output the slot just filled
    logic writeFill;   // write fetched line into victim slot
  } dpStrobe_t;

endpackage

// File: rtl/dpc_datapath.sv
module dpc_datapath
  import dpc_pkg::*;
#(
  parameter int TAG_W  = 4,
  parameter int IDX_W  = 3,
  parameter int OFF_W  = 2,
  parameter int THR_W  = 1,
  parameter int DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dpStrobe_t                     stb,
  input  logic [TAG_W+IDX_W+OFF_W-1:0]  reqAddr,
  input  logic [THR_W-1:0]              reqThread,
  input  logic [(DATA_W<<OFF_W)-1:0]    fillLine,
  output logic                          probeHit,
  output logic [IDX_W-1:0]              slotOut,
  output logic [DATA_W-1:0]             wordOut,
  output logic [TAG_W+IDX_W-1:0]        lineAddr
);

  localparam int LINES  = 1 << IDX_W;
  localparam int LINE_W = DATA_W << OFF_W;

  // latched request
  logic [TAG_W-1:0] rqTag;
  logic [IDX_W-1:0] rqIdx;
  logic [OFF_W-1:0] rqOff;
  logic [THR_W-1:0] rqThr;

  // line storage
  logic              lineVld  [LINES];
  logic              lineAlt  [LINES];
  logic [TAG_W-1:0]  lineTag  [LINES];
  logic [THR_W-1:0]  lineThr  [LINES];
  logic [LINE_W-1:0] lineData [LINES];

  logic [IDX_W-1:0] priIdx;
  logic [IDX_W-1:0] altIdx;
  logic [IDX_W-1:0] probeIdx;
  logic [IDX_W-1:0] victimIdx;
  logic             victimAlt;
  logic [IDX_W-1:0] fillSlot;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rqTag <= '0;
      rqIdx <= '0;
      rqOff <= '0;
      rqThr <= '0;
    end else if (stb.captureReq) begin
      {rqTag, rqIdx, rqOff} <= reqAddr;
      rqThr <= reqThread;
    end
  end

  // modulus and hashed index functions
  generate
    if (TAG_W >= IDX_W) begin : g_hashFull
      assign altIdx = rqIdx ^ rqTag[IDX_W-1:0];
    end else begin : g_hashShort
      assign altIdx = rqIdx ^ {{(IDX_W-TAG_W){1'b0}}, rqTag};
    end
  endgenerate

  assign priIdx   = rqIdx;
  assign probeIdx = stb.selAlt ? altIdx : priIdx;

  always_comb begin
    probeHit = lineVld[probeIdx]
            && (lineTag[probeIdx] == rqTag)
            && (lineThr[probeIdx] == rqThr)
            && (lineAlt[probeIdx] == stb.selAlt);
  end

  // replacement: empty hashed slot first, else primary slot
  assign victimAlt = !lineVld[altIdx];
  assign victimIdx = victimAlt ? altIdx : priIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillSlot <= '0;
    end else if (stb.writeFill) begin
      fillSlot <= victimIdx;
    end
  end

  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_line
      logic wrEn;
      assign wrEn = stb.writeFill && (victimIdx == IDX_W'(g));

      always_ff @(posedge clk) begin
        if (!rstN) begin
          lineVld[g] <= 1'b0;
          lineAlt[g] <= 1'b0;
        end else if (wrEn) begin
          lineVld[g] <= 1'b1;
          lineAlt[g] <= victimAlt;
        end
      end

      always_ff @(posedge clk) begin
        if (wrEn) begin
          lineTag[g]  <= rqTag;
          lineThr[g]  <= rqThr;
          lineData[g] <= fillLine;
        end
      end
    end
  endgenerate

  assign slotOut  = stb.selFill ? fillSlot : probeIdx;
  assign wordOut  = lineData[slotOut][rqOff*DATA_W +: DATA_W];
  assign lineAddr = {rqTag, rqIdx};

endmodule

// File: rtl/dpc_control.sv
module dpc_control
  import dpc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      probeHit,
  input  logic      memAck,
  output dpStrobe_t stb,
  output logic      reqReady,
  output logic      respValid,
  output logic      respHit,
  output logic      respSecond,
  output logic      memReqValid
);

  ctlState_t st;
  ctlState_t stNxt;

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stNxt;
  end

  always_comb begin
    stNxt       = st;
    stb         = '0;
    reqReady    = 1'b0;
    respValid   = 1'b0;
    respHit     = 1'b0;
    respSecond  = 1'b0;
    memReqValid = 1'b0;
    unique case (st)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          stb.captureReq = 1'b1;
          stNxt = ST_PRI;
        end
      end
      ST_PRI: begin
        if (probeHit) begin
          respValid = 1'b1;
          respHit   = 1'b1;
          stNxt     = ST_IDLE;
        end else begin
          stNxt = ST_ALT;
        end
      end
      ST_ALT: begin
        stb.selAlt = 1'b1;
        if (probeHit) begin
          respValid  = 1'b1;
          respHit    = 1'b1;
          respSecond = 1'b1;
          stNxt      = ST_IDLE;
        end else begin
          stNxt = ST_FILL;
        end
      end
      ST_FILL: begin
        memReqValid = 1'b1;
        if (memAck) begin
          stb.writeFill = 1'b1;
          stNxt = ST_RESP;
        end
      end
      ST_RESP: begin
        stb.selFill = 1'b1;
        respValid   = 1'b1;
        stNxt       = ST_IDLE;
      end
      default: stNxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/dual_probe_cache.sv
module dual_probe_cache
  import dpc_pkg::*;
#(
  parameter int TAG_W  = 4,
  parameter int IDX_W  = 3,
  parameter int OFF_W  = 2,
  parameter int THR_W  = 1,
  parameter int DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          reqValid,
  output logic                          reqReady,
  input  logic [TAG_W+IDX_W+OFF_W-1:0]  reqAddr,
  input  logic [THR_W-1:0]              reqThread,
  output logic                          respValid,
  output logic                          respHit,
  output logic                          respSecond,
  output logic [IDX_W-1:0]              respSlot,
  output logic [DATA_W-1:0]             respData,
  output logic                          memReqValid,
  output logic [TAG_W+IDX_W-1:0]        memReqAddr,
  input  logic                          memAck,
  input  logic [(DATA_W<<OFF_W)-1:0]    memData
);

  dpStrobe_t stb;
  logic      probeHit;

  dpc_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .probeHit   (probeHit),
    .memAck     (memAck),
    .stb        (stb),
    .reqReady   (reqReady),
    .respValid  (respValid),
    .respHit    (respHit),
    .respSecond (respSecond),
    .memReqValid(memReqValid)
  );

  dpc_datapath #(
    .TAG_W (TAG_W),
    .IDX_W (IDX_W),
    .OFF_W (OFF_W),
    .THR_W (THR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .reqAddr  (reqAddr),
    .reqThread(reqThread),
    .fillLine (memData),
    .probeHit (probeHit),
    .slotOut  (respSlot),
    .wordOut  (respData),
    .lineAddr (memReqAddr)
  );

endmodule

// File: rtl/dpc_checker.sv
module dpc_checker #(
  parameter int TAG_W = 4,
  parameter int IDX_W = 3
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   reqValid,
  input logic                   reqReady,
  input logic [TAG_W+IDX_W-1:0] reqLine,
  input logic                   respValid,
  input logic                   respHit,
  input logic                   respSecond,
  input logic [IDX_W-1:0]       respSlot,
  input logic                   memReqValid,
  input logic [TAG_W+IDX_W-1:0] memReqAddr,
  input logic                   memAck
);

  logic [TAG_W+IDX_W-1:0] capLine;
  logic [IDX_W-1:0]       capPri;
  logic [IDX_W-1:0]       capAlt;

  always_ff @(posedge clk) begin
    if (!rstN) capLine <= '0;
    else if (reqValid && reqReady) capLine <= reqLine;
  end

  assign capPri = capLine[IDX_W-1:0];
  assign capAlt = capPri ^ IDX_W'(capLine[TAG_W+IDX_W-1:IDX_W]);

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady); // R9
  AST_RESP_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> !reqReady); // R9
  AST_READY_AFTER_RESP: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> reqReady); // R9
  AST_PRI_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respHit && !respSecond) |-> $past(reqValid && reqReady)); // R3
  AST_PRI_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respHit && !respSecond) |-> (respSlot == capPri)); // R3
  AST_SEC_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respSecond) |-> (respHit && respSlot == capAlt)); // R4
  AST_MEMREQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memAck) |=> (memReqValid && $stable(memReqAddr))); // R7
  AST_MEMREQ_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (memReqAddr == capLine)); // R7
  AST_FILL_RESP: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memAck) |=> (respValid && !respHit)); // R8
  AST_FILL_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respHit) |-> (respSlot == capPri || respSlot == capAlt)); // R8

endmodule

bind dual_probe_cache dpc_checker #(
  .TAG_W(TAG_W),
  .IDX_W(IDX_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .reqLine    (reqAddr[TAG_W+IDX_W+OFF_W-1:OFF_W]),
  .respValid  (respValid),
  .respHit    (respHit),
  .respSecond (respSecond),
  .respSlot   (respSlot),
  .memReqValid(memReqValid),
  .memReqAddr (memReqAddr),
  .memAck     (memAck)
);

// File: tb/sim_dual_probe_cache.sv
`timescale 1ns/1ps
module sim_dual_probe_cache;

  localparam int TAG_W  = 4;
  localparam int IDX_W  = 3;
  localparam int OFF_W  = 2;
  localparam int THR_W  = 1;
  localparam int DATA_W = 8;
  localparam int LINES  = 1 << IDX_W;
  localparam int WORDS  = 1 << OFF_W;
  localparam int LINE_W = DATA_W * WORDS;
  localparam int ADDR_W = TAG_W + IDX_W + OFF_W;

  logic                  clk = 1'b0;
  logic                  rstN = 1'b0;
  logic                  reqValid = 1'b0;
  logic                  reqReady;
  logic [ADDR_W-1:0]     reqAddr = '0;
  logic [THR_W-1:0]      reqThread = '0;
  logic                  respValid, respHit, respSecond;
  logic [IDX_W-1:0]      respSlot;
  logic [DATA_W-1:0]     respData;
  logic                  memReqValid;
  logic [TAG_W+IDX_W-1:0] memReqAddr;
  logic                  memAck = 1'b0;
  logic [LINE_W-1:0]     memData = '0;

  int nChecks = 0;
  int nFail   = 0;
  int fillCnt = 0;
  bit done    = 0;

  // expected array contents, from the requirements
  bit                mVld [LINES];
  bit                mAlt [LINES];
  logic [TAG_W-1:0]  mTag [LINES];
  logic [THR_W-1:0]  mThr [LINES];
  logic [LINE_W-1:0] mData[LINES];

  always #4 clk = ~clk;

  dual_probe_cache #(
    .TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .THR_W(THR_W), .DATA_W(DATA_W)
  ) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqThread(reqThread), .respValid(respValid),
    .respHit(respHit), .respSecond(respSecond), .respSlot(respSlot),
    .respData(respData), .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memAck(memAck), .memData(memData)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", r, act, exp, $time);
    end
  endtask

  function automatic logic [LINE_W-1:0] genLine(input int n);
    logic [LINE_W-1:0] v;
    for (int k = 0; k < WORDS; k++) v[k*DATA_W +: DATA_W] = DATA_W'(n * 29 + k * 7 + 3);
    return v;
  endfunction

  // one lookup; missLbl names the requirement behind an expected primary miss
  task automatic doAccess(input logic [ADDR_W-1:0] a, input logic [THR_W-1:0] t,
                          input string missLbl);
    logic [TAG_W-1:0] tg;
    logic [IDX_W-1:0] ix, ax, vx;
    logic [OFF_W-1:0] of;
    bit pHit, aHit, vAlt;
    logic [LINE_W-1:0] ln;
    int dly;
    {tg, ix, of} = a;
    ax   = ix ^ tg[IDX_W-1:0];
    pHit = mVld[ix] && mTag[ix] == tg && mThr[ix] == t && !mAlt[ix];
    aHit = mVld[ax] && mTag[ax] == tg && mThr[ax] == t && mAlt[ax];

    @(negedge clk);
    chk("R9 ready before request", 32'(reqReady), 32'd1);
    reqAddr = a; reqThread = t; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R9 busy after accept", 32'(reqReady), 32'd0);
    if (pHit) begin
      chk("R3 primary respValid", 32'(respValid), 32'd1);
      chk("R3 primary hit/second", 32'({respHit, respSecond}), 32'b10);
      chk("R3 primary slot", 32'(respSlot), 32'(ix));
      chk("R2 primary word", 32'(respData), 32'(mData[ix][of*DATA_W +: DATA_W]));
      return;
    end
    chk(missLbl, 32'(respValid), 32'd0);
    @(negedge clk);
    if (aHit) begin
      chk("R4 secondary respValid", 32'(respValid), 32'd1);
      chk("R4 secondary hit/second", 32'({respHit, respSecond}), 32'b11);
      chk("R4 secondary slot", 32'(respSlot), 32'(ax));
      chk("R2 secondary word", 32'(respData), 32'(mData[ax][of*DATA_W +: DATA_W]));
      return;
    end
    chk("R6 no secondary hit", 32'(respValid), 32'd0);
    chk("R7 no early fetch", 32'(memReqValid), 32'd0);
    @(negedge clk);
    dly = fillCnt % 3;
    for (int w = 0; w <= dly; w++) begin
      chk("R7 fetch request", 32'(memReqValid), 32'd1);
      chk("R7 fetch address", 32'(memReqAddr), 32'({tg, ix}));
      chk("R9 busy during fetch", 32'(reqReady), 32'd0);
      if (w < dly) @(negedge clk);
    end
    ln = genLine(fillCnt);
    fillCnt++;
    memAck = 1'b1; memData = ln;
    vAlt = !mVld[ax];
    vx   = vAlt ? ax : ix;
    @(negedge clk);
    memAck = 1'b0;
    chk("R8 fill respValid", 32'(respValid), 32'd1);
    chk("R8 fill respHit", 32'(respHit), 32'd0);
    chk("R8 fill slot", 32'(respSlot), 32'(vx));
    chk("R2 fill word", 32'(respData), 32'(ln[of*DATA_W +: DATA_W]));
    mVld[vx] = 1'b1; mAlt[vx] = vAlt; mTag[vx] = tg; mThr[vx] = t; mData[vx] = ln;
  endtask

  initial begin
    for (int i = 0; i < LINES; i++) begin
      mVld[i] = 0; mAlt[i] = 0; mTag[i] = '0; mThr[i] = '0; mData[i] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset reqReady", 32'(reqReady), 32'd1);
    chk("R1 reset respValid", 32'(respValid), 32'd0);
    chk("R1 reset memReqValid", 32'(memReqValid), 32'd0);

    // tag 5, index 2: first miss fills hashed slot 7
    doAccess({4'd5, 3'd2, 2'd1}, 1'b0, "R1 first lookup misses");
    // same line, other word: second-probe hit at slot 7
    doAccess({4'd5, 3'd2, 2'd3}, 1'b0, "R4 primary misses");
    // same address from thread 1: miss, fills primary slot 2
    doAccess({4'd5, 3'd2, 2'd0}, 1'b1, "R5 other thread misses");
    // now a primary hit for thread 1
    doAccess({4'd5, 3'd2, 2'd2}, 1'b1, "R3 primary");
    // tag 5 index 7: slot 7 holds tag 5 thread 0 placed by hash
    doAccess({4'd5, 3'd7, 2'd1}, 1'b0, "R6 placement flag");
    // tag with zero low bits: both functions pick slot 3
    doAccess({4'd8, 3'd3, 2'd2}, 1'b0, "R4 same-slot hash");
    doAccess({4'd8, 3'd3, 2'd1}, 1'b0, "R4 same-slot hash");

    for (int p = 0; p < 2; p++)
      for (int t = 0; t < 2; t++)
        for (int la = 0; la < (1 << (TAG_W + IDX_W)); la++)
          doAccess({(TAG_W+IDX_W)'(la), OFF_W'(la + p)}, THR_W'(t), "R3 sweep primary");

    @(negedge clk);
    chk("R9 ready at end", 32'(reqReady), 32'd1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

endmodule